// File: doc/BRIEF.md
# Speculative Indirect Pointer Unit

This unit holds a register-address pointer for a four-stage in-order pipeline. The pointer is read and changed early, in stage 2, where it forms an operand register address. Branches and conditional execution resolve only in stage 4. Each stage-2 access gives a 2-bit mode. The mode picks pre- or post-increment, or pre- or post-decrement. In the same cycle the unit returns the effective address, taken straight from the pointer and the mode.

Because the change happens before the instruction is known to survive, the unit keeps a short history for each later stage. For each instruction in flight it records the pointer value before and after that instruction's update. A committed copy of the pointer advances only when a touching instruction leaves stage 4 still valid. When stage 4 flushes the trailing instructions, the live pointer falls back to the committed value. A direct load port writes the pointer, and a load takes priority over any speculative change made in the same cycle.

Top module: `spec_ptr_unit`

## Requirements
- R1: A synchronous active-high reset sets the live pointer, the committed pointer and all in-flight history to zero.
- R2: Mode encoding is bit 1 = pre (1) or post (0) and bit 0 = decrement (1) or increment (0). So 00 is post-increment, 01 post-decrement, 10 pre-increment and 11 pre-decrement. A pre mode outputs the updated value and a post mode outputs the old value.
- R3: The pointer is PTR_W (9) bits wide. Increment and decrement wrap modulo 512: 511 plus one gives 0, and 0 minus one gives 511.
- R4: A qualified stage-2 access (valid and access both high, no flush, no load) changes the live pointer by exactly one step at the next clock edge.
- R5: The committed pointer takes an instruction's updated value at the clock edge that ends that instruction's stage-4 cycle. This is the third edge after its stage-2 cycle.
- R6: In a flush cycle, the live pointer becomes the committed value as it stands after that edge. A stage-2 access made in that cycle has no effect on either pointer.
- R7: Instructions in stage 2 or stage 3 during a flush never change the committed pointer.
- R8: A direct load sets both pointers to the loaded value at the next edge. It overrides any stage-2 update, commit or flush in that cycle, and it cancels the pointer effect of every instruction still in flight.
- R9: The effective address is combinational: it is valid in the same cycle as the stage-2 access.
- R10: An access with the stage-2 valid flag low does not change either pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s2_valid | input | 1 | An instruction is present and valid in stage 2 |
| s2_acc | input | 1 | The stage-2 instruction uses the indirect pointer |
| s2_mode | input | 2 | Update mode: bit 1 pre/post, bit 0 decrement/increment |
| flush | input | 1 | Stage 4 cancels the instructions in stages 2 and 3 |
| wr_en | input | 1 | Direct load of the pointer, committed in stage 4 |
| wr_data | input | PTR_W | Value for the direct load |
| ea | output | PTR_W | Effective register address for the stage-2 access |
| ptr_spec | output | PTR_W | Live (speculative) pointer |
| ptr_arch | output | PTR_W | Committed (architectural) pointer |

## Verification
Some properties are checked by assertions on every cycle:
- a qualified access moves the live pointer by exactly one step;
- a flush always leaves the live pointer equal to the committed one;
- the two pointers agree whenever no touching instruction is in flight;
- the committed pointer holds still unless a valid touching instruction leaves stage 4 or a load arrives;
- the saved rollback value of the oldest in-flight instruction matches the committed value after the current edge.

Other behaviour can only be shown by the bench's scenarios, which compare against a model that tracks in-flight steps as deltas. These are the exact effective addresses in each mode, wrap-around at both ends, the three-edge commit latency, a load that lands while accesses are in flight, and ignored accesses.

// File: rtl/spu_pkg.sv
package spu_pkg;

  // bit 1: pre (1) / post (0); bit 0: decrement (1) / increment (0)
  typedef enum logic [1:0] {
    MODE_POST_INC = 2'b00,
    MODE_POST_DEC = 2'b01,
    MODE_PRE_INC  = 2'b10,
    MODE_PRE_DEC  = 2'b11
  } ptr_mode_e;

  function automatic logic mode_is_pre(input ptr_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_is_dec(input ptr_mode_e m);
    return m[0];
  endfunction

endpackage

// File: rtl/spu_step.sv
module spu_step
  import spu_pkg::*;
#(
  parameter int PTR_W = 9
) (
  input  logic [PTR_W-1:0] cur,
  input  ptr_mode_e        mode,
  output logic [PTR_W-1:0] nxt,
  output logic [PTR_W-1:0] ea
);

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  // modular one-step move; wrap falls out of the fixed width
  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] v,
                                                input logic dec);
    return dec ? (v - ONE) : (v + ONE);
  endfunction

  function automatic logic [PTR_W-1:0] pick_ea(input logic [PTR_W-1:0] old_v,
                                               input logic [PTR_W-1:0] new_v,
                                               input logic pre);
    return pre ? new_v : old_v;
  endfunction

  assign nxt = step_ptr(cur, mode_is_dec(mode));
  assign ea  = pick_ea(cur, nxt, mode_is_pre(mode));

endmodule

// File: rtl/spu_hist.sv
module spu_hist #(
  parameter int PTR_W = 9,
  parameter int DEPTH = 2   // stages between the update stage and the commit stage
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_v,
  input  logic             push_t,
  input  logic [PTR_W-1:0] push_old,
  input  logic [PTR_W-1:0] push_new,
  input  logic             flush,
  input  logic             wr_en,
  output logic             cm_v,
  output logic [PTR_W-1:0] cm_new,
  output logic             rb_hit,
  output logic [PTR_W-1:0] rb_val,
  output logic             inflight
);

  localparam int LAST = DEPTH - 1;

  logic             v_q [DEPTH];
  logic             t_q [DEPTH];
  logic [PTR_W-1:0] o_q [DEPTH];
  logic [PTR_W-1:0] n_q [DEPTH];

  logic             v_src [DEPTH];
  logic             t_src [DEPTH];
  logic [PTR_W-1:0] o_src [DEPTH];
  logic [PTR_W-1:0] n_src [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign v_src[k] = push_v;
      assign t_src[k] = push_t;
      assign o_src[k] = push_old;
      assign n_src[k] = push_new;
    end else begin : g_body
      assign v_src[k] = v_q[k-1];
      assign t_src[k] = t_q[k-1];
      assign o_src[k] = o_q[k-1];
      assign n_src[k] = n_q[k-1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q[k] <= 1'b0;
        t_q[k] <= 1'b0;
        o_q[k] <= '0;
        n_q[k] <= '0;
      end else begin
        // the flush kills everything behind the commit stage
        v_q[k] <= v_src[k] & ~flush;
        t_q[k] <= t_src[k] & v_src[k] & ~flush & ~wr_en;
        o_q[k] <= o_src[k];
        n_q[k] <= n_src[k];
      end
    end
  end

  assign cm_v   = v_q[LAST] & t_q[LAST];
  assign cm_new = n_q[LAST];

  // oldest cancelled touching entry (highest index below the commit stage)
  always_comb begin
    rb_hit   = 1'b0;
    rb_val   = '0;
    inflight = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (v_q[k] && t_q[k]) begin
        inflight = 1'b1;
        if (k < LAST) begin
          rb_hit = 1'b1;
          rb_val = o_q[k];
        end
      end
    end
  end

endmodule

// File: rtl/spu_commit.sv
module spu_commit #(
  parameter int PTR_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_data,
  input  logic             cm_v,
  input  logic [PTR_W-1:0] cm_new,
  output logic [PTR_W-1:0] arch_q,
  output logic [PTR_W-1:0] arch_nxt
);

  always_comb begin
    if (wr_en)     arch_nxt = wr_data;
    else if (cm_v) arch_nxt = cm_new;
    else           arch_nxt = arch_q;
  end

  always_ff @(posedge clk) begin
    if (rst) arch_q <= '0;
    else     arch_q <= arch_nxt;
  end

  // R7: without a valid touching commit or a load, the committed pointer holds
  a_r7_arch_holds: assert property (@(posedge clk) disable iff (rst)
    (!cm_v && !wr_en) |=> $stable(arch_q));

endmodule

// File: rtl/spec_ptr_unit.sv
module spec_ptr_unit
  import spu_pkg::*;
#(
  parameter int PTR_W = 9,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s2_valid,
  input  logic             s2_acc,
  input  logic [1:0]       s2_mode,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_data,
  output logic [PTR_W-1:0] ea,
  output logic [PTR_W-1:0] ptr_spec,
  output logic [PTR_W-1:0] ptr_arch
);

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W-1:0] spec_q, spec_nxt, step_nxt, arch_nxt;
  logic             acc_raw, acc_live;
  logic             cm_v, rb_hit, inflight;
  logic [PTR_W-1:0] cm_new, rb_val;

  // named internal events
  assign acc_raw  = s2_valid & s2_acc;
  assign acc_live = acc_raw & ~flush & ~wr_en;

  spu_step #(.PTR_W(PTR_W)) u_step (
    .cur  (spec_q),
    .mode (ptr_mode_e'(s2_mode)),
    .nxt  (step_nxt),
    .ea   (ea)
  );

  spu_hist #(.PTR_W(PTR_W), .DEPTH(DEPTH)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .push_v   (s2_valid),
    .push_t   (acc_raw),
    .push_old (spec_q),
    .push_new (step_nxt),
    .flush    (flush),
    .wr_en    (wr_en),
    .cm_v     (cm_v),
    .cm_new   (cm_new),
    .rb_hit   (rb_hit),
    .rb_val   (rb_val),
    .inflight (inflight)
  );

  spu_commit #(.PTR_W(PTR_W)) u_commit (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .cm_v     (cm_v),
    .cm_new   (cm_new),
    .arch_q   (ptr_arch),
    .arch_nxt (arch_nxt)
  );

  always_comb begin
    if (wr_en)         spec_nxt = wr_data;
    else if (flush)    spec_nxt = rb_hit ? rb_val : spec_q;
    else if (acc_live) spec_nxt = step_nxt;
    else               spec_nxt = spec_q;
  end

  always_ff @(posedge clk) begin
    if (rst) spec_q <= '0;
    else     spec_q <= spec_nxt;
  end

  assign ptr_spec = spec_q;

  // R1: reset clears both pointers
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (ptr_spec == '0 && ptr_arch == '0));

  // R4: a live access moves the pointer by exactly one step
  a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
    acc_live |=> (ptr_spec == $past(spec_q) + ONE || ptr_spec == $past(spec_q) - ONE));

  // R6: after a flush the live pointer equals the committed one
  a_r6_flush_restores: assert property (@(posedge clk) disable iff (rst)
    (flush && !wr_en) |=> (ptr_spec == ptr_arch));

  // R6: saved rollback value agrees with the commit path's next value
  a_r6_rollback_consistent: assert property (@(posedge clk) disable iff (rst)
    rb_hit |-> (rb_val == arch_nxt || wr_en));

  // R5: nothing touching in flight means the pointers agree
  a_r5_quiet_match: assert property (@(posedge clk) disable iff (rst)
    !inflight |-> (spec_q == ptr_arch));

  // R8: a load lands on both pointers
  a_r8_load_wins: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ptr_spec == $past(wr_data) && ptr_arch == $past(wr_data)));

endmodule

// File: tb/sim_spec_ptr_unit.sv
module sim_spec_ptr_unit;

  localparam int W = 9;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         s2_valid = 1'b0, s2_acc = 1'b0, flush = 1'b0, wr_en = 1'b0;
  logic [1:0]   s2_mode = 2'b00;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] ea, ptr_spec, ptr_arch;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model: live and committed values plus per-stage deltas
  logic [W-1:0] m_spec, m_arch, d3, d4;
  logic         v3, v4;

  always #10 clk = ~clk;   // 50 MHz

  spec_ptr_unit #(.PTR_W(W), .DEPTH(2)) u0 (
    .clk(clk), .rst(rst), .s2_valid(s2_valid), .s2_acc(s2_acc), .s2_mode(s2_mode),
    .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
    .ea(ea), .ptr_spec(ptr_spec), .ptr_arch(ptr_arch)
  );

  function automatic logic [W-1:0] delta_of(input logic [1:0] m);
    return m[0] ? {W{1'b1}} : W'(1);
  endfunction

  function automatic logic [W-1:0] exp_ea(input logic [W-1:0] s, input logic [1:0] m);
    return m[1] ? W'(s + delta_of(m)) : s;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_spec = '0; m_arch = '0; d3 = '0; d4 = '0; v3 = 0; v4 = 0;
  endtask

  // one cycle: drive at negedge, check ea, clock, update model, check pointers
  task automatic cycle(input logic sv, input logic sa, input logic [1:0] md,
                       input logic fl, input logic we, input logic [W-1:0] wd);
    logic [W-1:0] nd3;
    logic         acc;
    @(negedge clk);
    s2_valid = sv; s2_acc = sa; s2_mode = md; flush = fl; wr_en = we; wr_data = wd;
    acc = sv & sa;
    #2;
    if (acc) check("R2 R9 ea", ea, exp_ea(m_spec, md));
    nd3 = (acc && !fl && !we) ? delta_of(md) : '0;
    if (we) begin
      m_spec = wd; m_arch = wd;
    end else begin
      if (v4) m_arch = W'(m_arch + d4);
      if (fl)       m_spec = m_arch;
      else if (acc) m_spec = W'(m_spec + delta_of(md));
    end
    v4 = v3 & ~fl;
    d4 = (fl || we) ? '0 : d3;
    v3 = sv & ~fl;
    d3 = nd3;
    @(posedge clk);
    #2;
    check(we ? "R8 live" : (fl ? "R6 live" : (acc ? "R4 live" : "R10 live")), ptr_spec, m_spec);
    check(we ? "R8 arch" : (fl ? "R7 arch" : "R5 arch"), ptr_arch, m_arch);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    model_reset();
    repeat (3) @(negedge clk);
    @(negedge clk); rst = 1'b0;
    #2;
    check("R1 live", ptr_spec, '0);
    check("R1 arch", ptr_arch, '0);

    // R3: wrap downward from zero with pre-decrement, then upward
    cycle(1, 1, 2'b11, 0, 0, '0);        // ea 511
    cycle(1, 1, 2'b10, 0, 0, '0);        // back to 0
    cycle(0, 0, 2'b00, 0, 0, '0);
    cycle(0, 0, 2'b00, 0, 0, '0);
    check("R3 wrap arch", ptr_arch, '0);
    cycle(0, 0, 2'b00, 0, 1, 9'd511);    // R8 load 511
    cycle(1, 1, 2'b10, 0, 0, '0);        // R3 pre-inc 511 -> 0
    check("R3 wrap live", ptr_spec, '0);
    cycle(1, 1, 2'b00, 0, 0, '0);        // R2 post-inc
    cycle(1, 1, 2'b01, 0, 0, '0);        // R2 post-dec
    // R6 R7: flush with two touching in flight
    cycle(1, 1, 2'b10, 0, 0, '0);
    cycle(1, 1, 2'b10, 1, 0, '0);
    cycle(0, 0, 2'b00, 0, 0, '0);
    cycle(0, 0, 2'b00, 0, 0, '0);
    // R10: invalid access
    cycle(0, 1, 2'b10, 0, 0, '0);
    // R8: load with accesses in flight and a same-cycle flush
    cycle(1, 1, 2'b10, 0, 0, '0);
    cycle(1, 1, 2'b10, 0, 0, '0);
    cycle(1, 1, 2'b10, 1, 1, 9'd100);
    cycle(0, 0, 2'b00, 0, 0, '0);
    cycle(0, 0, 2'b00, 0, 0, '0);
    check("R8 hold", ptr_arch, 9'd100);

    for (int i = 0; i < 3000; i++) begin
      logic sv, sa, fl, we;
      sv = ($urandom % 10) < 8;
      sa = ($urandom % 10) < 6;
      fl = ($urandom % 10) == 0;
      we = ($urandom % 25) == 0;
      cycle(sv, sa, 2'($urandom), fl, we, W'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule